// File: doc/BRIEF.md
# Bus-Error Exception and Double-Fault Controller

This controller sits next to a processor's instruction sequencer and decides when a pending bus error or breakpoint is turned into an exception request. A bus error is not acted on at the moment it occurs. It is held in a latch and reported only when the current instruction completes. This means that any number of errors raised by one multi-cycle instruction, such as a read-modify-write, lead to a single exception. Breakpoint requests come from an internal source and from an external pin. Either one is captured only on the cycle that ends a bus cycle, and it waits in its own latch until the sequencer services it.

The block also guards two fragile windows. The first runs from reset until the first instruction completes. The second runs from the start of a bus-error exception sequence until the first instruction of its handler executes. A bus error in either window is a double bus fault. The controller then enters a halted state that suppresses every request and freezes its latches, and only reset leaves it. The sequencer reports its progress through single-cycle pulses: instruction complete, exception sequence start, and handler first instruction. A status view shows the current window and both latches.

Top module: `buserr_exc_ctrl`

## Requirements
- R1: While the window is normal, a cycle with `insn_done_i` high and a bus error pending (latched, or `bus_err_i` high in that same cycle) raises `exc_req_o` for exactly the next cycle, with `exc_type_o` = 2'b01. A bus error never raises a request on its own, away from an instruction completion.
- R2: In the normal window, `bus_err_i` sets the bus-error latch (`berr_pend_o`) on the next cycle. Repeated errors before the completion give one request only, and idle cycles after that request show `exc_req_o` low.
- R3: `window_o` encodes 2'b00 reset-pending, 2'b01 normal, 2'b10 bus-error-in-progress, 2'b11 halted. `exc_start_i` in the normal window with the bus-error latch set moves to 2'b10. `handler_first_i` in 2'b10 clears the latch and returns to 2'b01.
- R4: `bus_err_i` high in the bus-error-in-progress window (including the cycle of `handler_first_i`) enters the halted window on the next cycle.
- R5: `bus_err_i` high in the reset-pending window (including the cycle of the first `insn_done_i`) enters the halted window on the next cycle. The first `insn_done_i` without an error moves to normal.
- R6: `halt_o` is high exactly while the window is halted. In that window no request is raised and neither latch changes, until reset.
- R7: A breakpoint from `bkpt_int_i` or `bkpt_ext_i` sets `bkpt_pend_o` on the next cycle only if `cyc_end_i` is high in the same cycle. Without `cyc_end_i` it has no effect.
- R8: In the normal window, `insn_done_i` with no bus error pending and the breakpoint latch set raises `exc_req_o` for one cycle with `exc_type_o` = 2'b10. `exc_start_i` with no bus error latched clears the breakpoint latch.
- R9: When both are pending at a completion, the request carries type 2'b01 and the breakpoint latch stays set. It is requested later.
- R10: Reset (`rst_n` low, asynchronous) clears both latches, `halt_o` and `exc_req_o`, sets `exc_type_o` to 2'b00 and `window_o` to reset-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_err_i | input | 1 | Bus error seen in this cycle |
| cyc_end_i | input | 1 | Current bus cycle ends in this cycle |
| bkpt_int_i | input | 1 | Internal breakpoint request |
| bkpt_ext_i | input | 1 | External breakpoint pin |
| insn_done_i | input | 1 | Pulse: an instruction completes |
| handler_first_i | input | 1 | Pulse: first handler instruction executes |
| exc_start_i | input | 1 | Pulse: exception sequence begins |
| exc_req_o | output | 1 | Single-cycle exception request |
| exc_type_o | output | 2 | Request type: 01 bus error, 10 breakpoint |
| halt_o | output | 1 | Double bus fault halt |
| berr_pend_o | output | 1 | Bus-error latch state |
| bkpt_pend_o | output | 1 | Breakpoint latch state |
| window_o | output | 2 | Current window code |

## Verification
Directed sequences try errors bunched inside one instruction against a single error. This separates merging from per-error reporting. Errors are placed just before, on, and after each window edge, which shows whether the window bounds are exact. Breakpoints are sent with and without a bus-cycle end, and alongside a bus error, to show capture gating and priority. A long random run with occasional resets then compares every output on every cycle against a reference model built from the requirements.

// File: rtl/bexc_pkg.sv
package bexc_pkg;

    localparam int XT_W  = 2;
    localparam int WIN_W = 2;

    typedef enum logic [WIN_W-1:0] {
        WIN_RESET = 2'b00,
        WIN_RUN   = 2'b01,
        WIN_BERR  = 2'b10,
        WIN_HALT  = 2'b11
    } win_e;

    typedef enum logic [XT_W-1:0] {
        XT_NONE   = 2'b00,
        XT_BUSERR = 2'b01,
        XT_BREAK  = 2'b10,
        XT_RSVD   = 2'b11
    } xtype_e;

endpackage

// File: rtl/fault_window.sv
module fault_window
    import bexc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_err_i,
    input  logic insn_done_i,
    input  logic handler_first_i,
    input  logic exc_start_i,
    output win_e win_o,
    output logic berr_pend_o
);

    typedef struct packed {
        win_e win;
        logic berr;
    } fw_state_t;

    localparam fw_state_t FW_RESET = '{win: WIN_RESET, berr: 1'b0};

    fw_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.win)
            WIN_RESET: begin
                if (bus_err_i) begin
                    s_d.win  = WIN_HALT;
                    s_d.berr = 1'b1;
                end else if (insn_done_i) begin
                    s_d.win = WIN_RUN;
                end
            end
            WIN_RUN: begin
                if (bus_err_i) begin
                    s_d.berr = 1'b1;
                end
                if (exc_start_i && s_q.berr) begin
                    s_d.win = WIN_BERR;
                end
            end
            WIN_BERR: begin
                if (bus_err_i) begin
                    s_d.win = WIN_HALT;
                end else if (handler_first_i) begin
                    s_d.berr = 1'b0;
                    s_d.win  = WIN_RUN;
                end
            end
            WIN_HALT: begin
                s_d = s_q;
            end
            default: s_d = FW_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= FW_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign win_o       = s_q.win;
    assign berr_pend_o = s_q.berr;

    assert_berr_window_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o == WIN_BERR && bus_err_i) |=> (win_o == WIN_HALT));

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o == WIN_HALT) |=> (win_o == WIN_HALT && $stable(berr_pend_o)));

    assert_handler_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o == WIN_BERR && handler_first_i && !bus_err_i) |=> (!berr_pend_o && win_o == WIN_RUN));

endmodule

// File: rtl/bkpt_capture.sv
module bkpt_capture #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               cyc_end_i,
    input  logic               freeze_i,
    input  logic               clear_i,
    output logic               pend_o
);

    typedef struct packed {
        logic pend;
    } bk_state_t;

    bk_state_t s_d, s_q;

    logic [NUM_SRC:0] any_chain;

    assign any_chain[0] = 1'b0;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_or
        assign any_chain[g+1] = any_chain[g] | src_i[g];
    end

    always_comb begin
        s_d = s_q;
        if (!freeze_i) begin
            s_d.pend = (s_q.pend & ~clear_i) | (cyc_end_i & any_chain[NUM_SRC]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

    assert_bkpt_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && cyc_end_i && (|src_i)) |=> pend_o);

    assert_bkpt_needs_cycle_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_end_i && !pend_o) |=> !pend_o);

endmodule

// File: rtl/exc_issue.sv
module exc_issue
    import bexc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   boundary_i,
    input  logic   berr_now_i,
    input  logic   bkpt_i,
    output logic   req_o,
    output xtype_e type_o
);

    typedef struct packed {
        logic   req;
        xtype_e typ;
    } is_state_t;

    is_state_t s_d, s_q;

    always_comb begin
        s_d.req = 1'b0;
        s_d.typ = XT_NONE;
        if (boundary_i) begin
            if (berr_now_i) begin
                s_d.req = 1'b1;
                s_d.typ = XT_BUSERR;
            end else if (bkpt_i) begin
                s_d.req = 1'b1;
                s_d.typ = XT_BREAK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req: 1'b0, typ: XT_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o  = s_q.req;
    assign type_o = s_q.typ;

    assert_req_on_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(boundary_i));

    assert_req_type_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ($countones(type_o) == 1));

    assert_berr_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && berr_now_i) |=> (req_o && type_o == XT_BUSERR));

endmodule

// File: rtl/buserr_exc_ctrl.sv
module buserr_exc_ctrl
    import bexc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_err_i,
    input  logic             cyc_end_i,
    input  logic             bkpt_int_i,
    input  logic             bkpt_ext_i,
    input  logic             insn_done_i,
    input  logic             handler_first_i,
    input  logic             exc_start_i,
    output logic             exc_req_o,
    output logic [XT_W-1:0]  exc_type_o,
    output logic             halt_o,
    output logic             berr_pend_o,
    output logic             bkpt_pend_o,
    output logic [WIN_W-1:0] window_o
);

    localparam int NUM_BKPT_SRC = 2;

    win_e   win;
    logic   berr_pend;
    logic   bkpt_pend;
    logic   in_run;
    logic   bkpt_clear;
    xtype_e xtype;

    fault_window u_window (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_err_i       (bus_err_i),
        .insn_done_i     (insn_done_i),
        .handler_first_i (handler_first_i),
        .exc_start_i     (exc_start_i),
        .win_o           (win),
        .berr_pend_o     (berr_pend)
    );

    assign in_run     = (win == WIN_RUN);
    assign bkpt_clear = in_run & exc_start_i & ~berr_pend;

    bkpt_capture #(
        .NUM_SRC (NUM_BKPT_SRC)
    ) u_bkpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     ({bkpt_ext_i, bkpt_int_i}),
        .cyc_end_i (cyc_end_i),
        .freeze_i  (win == WIN_HALT),
        .clear_i   (bkpt_clear),
        .pend_o    (bkpt_pend)
    );

    exc_issue u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (in_run & insn_done_i),
        .berr_now_i (berr_pend | bus_err_i),
        .bkpt_i     (bkpt_pend),
        .req_o      (exc_req_o),
        .type_o     (xtype)
    );

    assign exc_type_o  = xtype;
    assign halt_o      = (win == WIN_HALT);
    assign berr_pend_o = berr_pend;
    assign bkpt_pend_o = bkpt_pend;
    assign window_o    = win;

    assert_halt_blocks_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !exc_req_o);

    assert_reset_window_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o == 2'b00 && bus_err_i) |=> halt_o);

    assert_bkpt_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o == 2'b01 && insn_done_i && bus_err_i && bkpt_pend_o && !exc_start_i) |=> bkpt_pend_o);

endmodule

// File: tb/buserr_exc_ctrl_test.sv
module buserr_exc_ctrl_test;

    typedef struct packed {
        logic [1:0] win;
        logic       berr;
        logic       bkpt;
        logic       req;
        logic [1:0] typ;
    } mst_t;

    localparam mst_t M_RESET = '{win: 2'b00, berr: 1'b0, bkpt: 1'b0, req: 1'b0, typ: 2'b00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_err = 1'b0, cyc_end = 1'b0, bk_int = 1'b0, bk_ext = 1'b0;
    logic insn_done = 1'b0, hfirst = 1'b0, xstart = 1'b0;
    logic       exc_req, halt, berr_pend, bkpt_pend;
    logic [1:0] exc_type, window;

    int checks = 0;
    int errors = 0;
    mst_t m;

    always #10 clk = ~clk;

    buserr_exc_ctrl uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_err_i       (bus_err),
        .cyc_end_i       (cyc_end),
        .bkpt_int_i      (bk_int),
        .bkpt_ext_i      (bk_ext),
        .insn_done_i     (insn_done),
        .handler_first_i (hfirst),
        .exc_start_i     (xstart),
        .exc_req_o       (exc_req),
        .exc_type_o      (exc_type),
        .halt_o          (halt),
        .berr_pend_o     (berr_pend),
        .bkpt_pend_o     (bkpt_pend),
        .window_o        (window)
    );

    function automatic mst_t ref_next(mst_t s, logic be, logic ce, logic bi, logic bx,
                                      logic id, logic hf, logic xs);
        mst_t n;
        logic cap;
        n     = s;
        n.req = 1'b0;
        n.typ = 2'b00;
        cap   = ce & (bi | bx);
        case (s.win)
            2'b00: begin
                n.bkpt = s.bkpt | cap;
                if (be) begin
                    n.win  = 2'b11;
                    n.berr = 1'b1;
                end else if (id) begin
                    n.win = 2'b01;
                end
            end
            2'b01: begin
                if (id) begin
                    if (s.berr | be) begin
                        n.req = 1'b1;
                        n.typ = 2'b01;
                    end else if (s.bkpt) begin
                        n.req = 1'b1;
                        n.typ = 2'b10;
                    end
                end
                n.berr = s.berr | be;
                n.bkpt = (s.bkpt & ~(xs & ~s.berr)) | cap;
                if (xs && s.berr) n.win = 2'b10;
            end
            2'b10: begin
                n.bkpt = s.bkpt | cap;
                if (be) begin
                    n.win = 2'b11;
                end else if (hf) begin
                    n.berr = 1'b0;
                    n.win  = 2'b01;
                end
            end
            default: begin
            end
        endcase
        return n;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check(exc_req === m.req,    tag, "R1 exc_req",  int'(exc_req),   int'(m.req));
        check(exc_type === m.typ,   tag, "R8 exc_type", int'(exc_type),  int'(m.typ));
        check(halt === (m.win == 2'b11), tag, "R6 halt", int'(halt), int'(m.win == 2'b11));
        check(window === m.win,     tag, "R3 window",   int'(window),    int'(m.win));
        check(berr_pend === m.berr, tag, "R2 berr",     int'(berr_pend), int'(m.berr));
        check(bkpt_pend === m.bkpt, tag, "R7 bkpt",     int'(bkpt_pend), int'(m.bkpt));
    endtask

    task automatic cyc(input logic be, input logic ce, input logic bi, input logic bx,
                       input logic id, input logic hf, input logic xs, input string tag);
        bus_err = be; cyc_end = ce; bk_int = bi; bk_ext = bx;
        insn_done = id; hfirst = hf; xstart = xs;
        m = ref_next(m, be, ce, bi, bx, id, hf, xs);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset(input string tag);
        bus_err = 0; cyc_end = 0; bk_int = 0; bk_ext = 0;
        insn_done = 0; hfirst = 0; xstart = 0;
        rst_n = 1'b0;
        m = M_RESET;
        @(negedge clk);
        compare(tag);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7033));
        m = M_RESET;
        @(negedge clk);
        do_reset("R10 reset state");

        // R5: error before first instruction -> halt; R6 sticky
        cyc(1, 0, 0, 0, 0, 0, 0, "R5 error in reset window");
        cyc(0, 1, 1, 1, 1, 1, 1, "R6 halted ignores inputs");
        cyc(1, 0, 0, 0, 1, 0, 0, "R6 halted no request");
        do_reset("R10 reset leaves halt");
        cyc(1, 0, 0, 0, 1, 0, 0, "R5 error on first completion");
        do_reset("R10");

        // R2 merge, R1 request, R3 window walk
        cyc(0, 0, 0, 0, 1, 0, 0, "R5 first instruction ends window");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 first error latched");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 second error same instruction");
        idle("R1 no request before completion");
        cyc(1, 0, 0, 0, 1, 0, 0, "R1 completion raises request");
        idle("R2 single request only");
        cyc(0, 0, 0, 0, 0, 0, 1, "R3 enter bus-error window");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3 handler first clears latch");
        idle("R3");

        // R4 double fault in handler window
        cyc(1, 0, 0, 0, 1, 0, 0, "R1 error on completion cycle");
        cyc(0, 0, 0, 0, 0, 0, 1, "R3");
        cyc(1, 0, 0, 0, 0, 1, 0, "R4 error with handler first");
        idle("R6 stays halted");

        // R7 capture gating, R8 breakpoint request
        do_reset("R10");
        cyc(0, 0, 0, 0, 1, 0, 0, "R5");
        cyc(0, 0, 1, 1, 0, 0, 0, "R7 no capture without cycle end");
        cyc(0, 1, 0, 1, 0, 0, 0, "R7 external captured at cycle end");
        cyc(0, 0, 0, 0, 1, 0, 0, "R8 breakpoint request");
        cyc(0, 0, 0, 0, 0, 0, 1, "R8 service clears latch");
        cyc(0, 1, 1, 0, 0, 0, 0, "R7 internal captured");

        // R9 priority
        cyc(1, 0, 0, 0, 1, 0, 0, "R9 bus error wins");
        cyc(0, 0, 0, 0, 0, 0, 1, "R9 breakpoint kept");
        cyc(0, 0, 0, 0, 0, 1, 0, "R3");
        cyc(0, 0, 0, 0, 1, 0, 0, "R9 breakpoint served later");
        cyc(0, 0, 0, 0, 0, 0, 1, "R8");

        // random phase
        for (int i = 0; i < 5000; i++) begin
            if (($urandom % 400) == 0) begin
                do_reset("R10 random reset");
            end else begin
                cyc(($urandom % 12) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
                    ($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
                    ($urandom % 5) == 0, "random");
                if (m.win == 2'b11 && ($urandom % 8) == 0) do_reset("R10");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule